// File: doc/BRIEF.md
# I2C Slave Receiver with Buffer-Full Handling

This block is the receive side of an I2C target with a 7-bit address. It watches the bus clock and data lines after they pass through a two-stage synchroniser. It recognises Start and Stop conditions and shifts in each byte. It compares the address byte with a programmable address and acknowledges matching bytes on its own by pulling the data line low. The block never drives the line high.

Each acknowledged byte goes into a one-byte holding buffer, and a buffer-full flag marks it. Software reads the buffer by pulsing a read strobe, which empties it. A byte may complete while the previous one is still unread, or while an overflow is still pending. In that case the block withholds the acknowledge and leaves the buffer as it was, but it still raises the interrupt flag. This lets software see that a byte was refused. An optional mode also raises the interrupt on every Start and Stop.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, `sda_pull`, `buf_full`, `ovf` and `irq` are 0 and `rx_data` is 0x00.
- R2: A Start is SDA falling while SCL stays high, and a Stop is SDA rising while SCL stays high. SDA changes while SCL is low are data, not conditions.
- R3: After a Start, bits are shifted in MSB first on each rising SCL edge. At the eighth falling SCL edge, bits 7:1 of the byte are compared with `own_addr`. On a mismatch the block sends no ACK, sets no flag, and ignores the bus until the next Start.
- R4: On an address match with `buf_full` and `ovf` both clear, the whole 8-bit byte (R/W bit in bit 0) is loaded into `rx_data` and `buf_full` is set. `sda_pull` is 1 from the eighth falling SCL edge until the ninth falling SCL edge, and 0 after that.
- R5: `irq` is set at the ninth falling SCL edge of every byte that follows a matched address, or that is the matched address byte itself. It stays 0 while SCL is high in the ninth clock.
- R6: Data bytes after a matched address receive the same ACK, buffer load and interrupt as the address byte.
- R7: If `buf_full` or `ovf` is 1 when a byte completes, the block sends no ACK and leaves `rx_data` unchanged, but still sets `irq`.
- R8: `ovf` is set when a byte completes while `buf_full` is 1. It is cleared only by a one-cycle `ovf_clr` pulse. Reading the buffer does not clear it.
- R9: A one-cycle `rd_buf` pulse clears `buf_full`, and a one-cycle `irq_clr` pulse clears `irq`.
- R10: With `ss_irq_en` at 1, a Start and a Stop each set `irq`. With `ss_irq_en` at 0, neither does.
- R11: The data line is open-drain. `sda_pull` at 1 means drive low, and at 0 means release. The block is never the source of a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock pin level |
| sda_in | input | 1 | Bus data pin level |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| own_addr | input | 7 | Programmed 7-bit target address |
| ss_irq_en | input | 1 | 1 makes Start and Stop raise the interrupt |
| rd_buf | input | 1 | Read strobe, empties the holding buffer |
| ovf_clr | input | 1 | Write strobe clearing the overflow flag |
| irq_clr | input | 1 | Write strobe clearing the interrupt flag |
| rx_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Holding buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | Interrupt flag |

## Verification
The receive path is tried with several input patterns. A matching address followed by data that is read promptly shows normal acknowledge and load. A foreign address followed by further bytes shows that a mismatched transfer is ignored. A matched transfer left unread, then read with the overflow still pending, then cleared, separates the buffer-full and overflow suppression paths from each other and from normal reception. Start and Stop are issued with the interrupt mode on and off, and the interrupt is sampled both before and after the ninth falling clock edge to pin down when it is set.

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ss_irq_en,
  input  logic              rd_buf,
  input  logic              ovf_clr,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_ACK} state_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  state_t            state;

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end = (state == S_ADDR || state == S_DATA) && scl_fall
                  && bitcnt == CNT_W'(DATA_W);
  wire addr_hit = shreg[DATA_W-1:DATA_W-ADDR_W] == own_addr;
  wire take     = byte_end && (state == S_DATA || addr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      state    <= S_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_DATA: begin
          if (scl_rise && bitcnt < CNT_W'(DATA_W)) begin
            shreg  <= {shreg[DATA_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_end) begin
            if (take) begin
              state    <= S_ACK;
              sda_pull <= ~buf_full & ~ovf;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          state    <= S_DATA;
        end
        default: ;
      endcase
    end
  end

  wire ack_end = state == S_ACK && scl_fall && !start_c && !stop_c;
  wire do_load = take && !start_c && !stop_c && !buf_full && !ovf;
  wire do_ovf  = take && !start_c && !stop_c && buf_full;
  wire ss_irq  = ss_irq_en && (start_c || stop_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (do_load)      rx_data <= shreg;
      if (do_load)      buf_full <= 1'b1;
      else if (rd_buf)  buf_full <= 1'b0;
      if (do_ovf)       ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (ack_end || ss_irq) irq <= 1'b1;
      else if (irq_clr)      irq <= 1'b0;
    end
  end

  assert_pull_only_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> state == S_ACK);
  assert_ack_needs_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(!buf_full && !ovf));
  assert_buf_changes_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> buf_full);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(buf_full));
  assert_ovf_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(ovf_clr));
  assert_full_clear_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rd_buf));

endmodule

// File: tb/i2c_rx_slave_tb.sv
module i2c_rx_slave_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_pull;
  logic [6:0] own_addr = 7'h5A;
  logic ss_irq_en = 0, rd_buf = 0, ovf_clr = 0, irq_clr = 0;
  logic [7:0] rx_data;
  logic buf_full, ovf, irq;
  wire  sda_line = sda_m & ~sda_pull;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_rx_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .own_addr(own_addr), .ss_irq_en(ss_irq_en),
    .rd_buf(rd_buf), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
    .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .irq(irq));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(1); s = 0; tick(1);
  endtask

  task automatic start_cond();
    sda_m = 1; tick(5); scl_m = 1; tick(10); sda_m = 0; tick(10); scl_m = 0; tick(10);
  endtask

  task automatic stop_cond();
    sda_m = 0; tick(10); scl_m = 1; tick(10); sda_m = 1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack,
                           output logic irq_pre, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(10); scl_m = 1; tick(10); scl_m = 0;
    end
    sda_m = 1; tick(10); scl_m = 1; tick(5);
    ack = ~sda_line; irq_pre = irq;
    tick(5); scl_m = 0; tick(10);
    rel = ~sda_pull;
  endtask

  task automatic t_reset();
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rx_data", rx_data, 0);
  endtask

  task automatic t_match();
    logic a, ip, rl;
    start_cond();
    send_byte({7'h5A, 1'b0}, a, ip, rl);
    chk("R4 addr ack", a, 1);
    chk("R4 sda released", rl, 1);
    chk("R4 rx_data addr", rx_data, 8'hB4);
    chk("R4 buf_full", buf_full, 1);
    chk("R5 irq before 9th fall", ip, 0);
    chk("R5 irq after 9th fall", irq, 1);
    pulse(rd_buf); pulse(irq_clr);
    chk("R9 rd clears full", buf_full, 0);
    chk("R9 irq_clr", irq, 0);
    send_byte(8'hC3, a, ip, rl);
    chk("R6 data ack", a, 1);
    chk("R3 R6 data MSB first", rx_data, 8'hC3);
    chk("R6 irq", irq, 1);
    pulse(rd_buf); pulse(irq_clr);
    stop_cond();
    chk("R10 stop no irq when off", irq, 0);
  endtask

  task automatic t_mismatch();
    logic a, ip, rl;
    start_cond();
    send_byte({7'h33, 1'b0}, a, ip, rl);
    chk("R3 mismatch no ack", a, 0);
    chk("R3 mismatch no irq", irq, 0);
    chk("R3 mismatch no load", buf_full, 0);
    send_byte(8'hB4, a, ip, rl);
    chk("R3 idle ignores byte ack", a, 0);
    chk("R3 idle ignores byte irq", irq, 0);
    stop_cond();
    send_byte(8'hB4, a, ip, rl);
    chk("R2 no start after stop", a, 0);
  endtask

  task automatic t_overflow();
    logic a, ip, rl;
    start_cond();
    send_byte({7'h5A, 1'b1}, a, ip, rl);
    chk("R4 addr ack rd", a, 1);
    pulse(irq_clr);
    send_byte(8'h11, a, ip, rl);
    chk("R7 full no ack", a, 0);
    chk("R7 buffer unchanged", rx_data, 8'hB5);
    chk("R8 ovf set", ovf, 1);
    chk("R7 irq still set", irq, 1);
    pulse(rd_buf); pulse(irq_clr);
    chk("R8 read keeps ovf", ovf, 1);
    send_byte(8'h22, a, ip, rl);
    chk("R7 ovf no ack", a, 0);
    chk("R7 ovf buffer unchanged", rx_data, 8'hB5);
    chk("R7 ovf no load", buf_full, 0);
    chk("R7 ovf irq", irq, 1);
    pulse(ovf_clr); pulse(irq_clr);
    chk("R8 ovf_clr", ovf, 0);
    send_byte(8'h44, a, ip, rl);
    chk("R6 ack after clear", a, 1);
    chk("R6 load after clear", rx_data, 8'h44);
    stop_cond();
    pulse(rd_buf); pulse(irq_clr);
  endtask

  task automatic t_ss_irq();
    ss_irq_en = 1;
    start_cond();
    chk("R10 R2 start irq", irq, 1);
    pulse(irq_clr);
    stop_cond();
    chk("R10 R2 stop irq", irq, 1);
    pulse(irq_clr);
    ss_irq_en = 0;
    start_cond();
    chk("R10 start off", irq, 0);
    stop_cond();
    chk("R10 stop off", irq, 0);
    chk("R11 released idle", sda_pull, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(5);
    t_match();
    t_mismatch();
    t_overflow();
    t_ss_irq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule